// File: doc/BRIEF.md
# PC Update and Exception Capture Unit

This block is the slice of a multicycle 32-bit processor datapath that owns the program counter. It also owns the two registers that record a trap: the saved return address (EPC) and a 32-bit cause word. Each clock cycle the control sequencer drives a set of strobes. The block uses them to decide whether the PC loads and from which of five sources. It also decides whether the ALU result is captured as the return address, and whether an exception code is recorded.

A conditional branch fires on the ALU zero flag. A polarity select can invert that flag, so one datapath serves both branch-if-equal and branch-if-not-equal. The PC sources are:

- the live ALU result;
- the registered ALU output;
- a jump target built from the upper PC nibble and a 26-bit word index;
- a fixed trap vector;
- the saved return address, used to resume after a handler.

All three registers are plain clocked registers with a synchronous active-high reset. The block has no state machine of its own. Its only sequencing is the cycle-by-cycle choice made by the external control sequencer.

Top module: `npc_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q`, `epc_q` and `cause_q` all become 0 after that edge.
- R2: The PC load enable is `pc_wr | (pc_wr_cond & (alu_zero ^ br_ne))`. So the branch condition is zero when `br_ne`=0 and not-zero when `br_ne`=1. When the enable is low, `pc_q` keeps its value.
- R3: With the enable high, `pc_sel`=0 loads `alu_result` and `pc_sel`=1 loads `alu_reg`.
- R4: With the enable high, `pc_sel`=2 loads `{pc_q[31:28], ir_target[25:0], 2'b00}`.
- R5: With the enable high, `pc_sel`=3 loads the trap vector 32'hC000_0000.
- R6: With the enable high, `pc_sel`=4 loads the value `epc_q` held before the edge.
- R7: `pc_sel` values 5, 6 and 7 leave `pc_q` unchanged even when the enable is high.
- R8: When `epc_wr` is high, `epc_q` loads `alu_result`; otherwise it holds.
- R9: When `cause_wr` is high, `cause_q` loads `cause_code` zero-extended to 32 bits; otherwise it holds. Code 0 means undefined opcode and code 1 means arithmetic overflow.
- R10: When `epc_wr` is high in the same cycle as a PC load with `pc_sel`=4, the PC takes the old EPC and the EPC takes the new ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_result | input | 32 | Combinational ALU result |
| alu_reg | input | 32 | Registered ALU output |
| ir_target | input | 26 | Low 26 bits of the instruction register (jump word index) |
| alu_zero | input | 1 | ALU zero flag |
| pc_wr | input | 1 | Unconditional PC write strobe |
| pc_wr_cond | input | 1 | Conditional (branch) PC write strobe |
| br_ne | input | 1 | Branch polarity: 0 taken on zero, 1 taken on non-zero |
| pc_sel | input | 3 | PC source select (0..4 used, 5..7 no load) |
| epc_wr | input | 1 | Return-address capture strobe |
| cause_wr | input | 1 | Cause register write strobe |
| cause_code | input | 1 | Exception code to record |
| pc_q | output | 32 | Current program counter |
| epc_q | output | 32 | Saved return address |
| cause_q | output | 32 | Exception cause word |

## Verification
Every result is due exactly one rising edge after the strobes that cause it. The bench therefore drives inputs just after a falling edge. It compares all three outputs one time unit after the next rising edge against a model that it updates with the same one-edge delay. A sweep covers every combination of `pc_sel`, `pc_wr`, `pc_wr_cond`, `alu_zero` and `br_ne` with changing data and changing capture strobes. Directed cases add reset in mid-run and the same-cycle return-and-capture case. These cases are also checked at that single edge.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // PC source encodings; the control sequencer depends on these values
    typedef enum logic [2:0] {
        SRC_ALU    = 3'd0,
        SRC_ALUREG = 3'd1,
        SRC_JUMP   = 3'd2,
        SRC_TRAP   = 3'd3,
        SRC_RETURN = 3'd4
    } pc_src_e;

    localparam logic [31:0] TRAP_VECTOR_DEFAULT = 32'hC000_0000;

endpackage

// File: rtl/npc_branch_gate.sv
module npc_branch_gate (
    input  logic clk,
    input  logic rst,
    input  logic pc_wr,
    input  logic pc_wr_cond,
    input  logic br_ne,
    input  logic alu_zero,
    output logic load_en
);

    logic cond_met;

    always_comb begin
        cond_met = br_ne ? !alu_zero : alu_zero;
        load_en  = pc_wr || (pc_wr_cond && cond_met);
    end

    // R2: an unconditional write always enables the load
    a_r2_uncond_loads: assert property (@(posedge clk) disable iff (rst)
        pc_wr |-> load_en);

    // R2: no strobe means no load
    a_r2_idle_no_load: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !pc_wr_cond) |-> !load_en);

endmodule

// File: rtl/npc_source_mux.sv
module npc_source_mux
    import npc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          JUMP_W   = 26,
    parameter logic [31:0] TRAP_VEC = TRAP_VECTOR_DEFAULT
) (
    input  logic [2:0]               pc_sel,
    input  logic [XLEN-1:0]          alu_result,
    input  logic [XLEN-1:0]          alu_reg,
    input  logic [XLEN-JUMP_W-3:0]   pc_hi,
    input  logic [JUMP_W-1:0]        ir_target,
    input  logic [XLEN-1:0]          epc_val,
    output logic [XLEN-1:0]          next_pc,
    output logic                     sel_valid
);

    logic [XLEN-1:0] jump_addr;

    always_comb begin
        jump_addr = {pc_hi, ir_target, 2'b00};
        next_pc   = '0;
        sel_valid = 1'b1;
        case (pc_src_e'(pc_sel))
            SRC_ALU:    next_pc = alu_result;
            SRC_ALUREG: next_pc = alu_reg;
            SRC_JUMP:   next_pc = jump_addr;
            SRC_TRAP:   next_pc = TRAP_VEC[XLEN-1:0];
            SRC_RETURN: next_pc = epc_val;
            default:    sel_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_exc_capture.sv
module npc_exc_capture #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              epc_wr,
    input  logic [XLEN-1:0]   alu_result,
    input  logic              cause_wr,
    input  logic [CODE_W-1:0] cause_code,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   cause_q
);

    localparam int PAD_W = XLEN - CODE_W;

    logic [XLEN-1:0] cause_ext;
    assign cause_ext = {{PAD_W{1'b0}}, cause_code};

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else begin
            if (epc_wr)   epc_q   <= alu_result;
            if (cause_wr) cause_q <= cause_ext;
        end
    end

    // R8: capture of the ALU result
    a_r8_epc_capture: assert property (@(posedge clk) disable iff (rst)
        epc_wr |=> epc_q == $past(alu_result));

    // R8: hold when not written
    a_r8_epc_hold: assert property (@(posedge clk) disable iff (rst)
        !epc_wr |=> $stable(epc_q));

    // R9: cause value zero-extended from the code
    a_r9_cause_load: assert property (@(posedge clk) disable iff (rst)
        cause_wr |=> (cause_q[CODE_W-1:0] == $past(cause_code)) && (cause_q[XLEN-1:CODE_W] == '0));

    // R9: hold when not written
    a_r9_cause_hold: assert property (@(posedge clk) disable iff (rst)
        !cause_wr |=> $stable(cause_q));

endmodule

// File: rtl/npc_pc_unit.sv
module npc_pc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          JUMP_W   = 26,
    parameter int          CODE_W   = 1,
    parameter logic [31:0] TRAP_VEC = TRAP_VECTOR_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   alu_result,
    input  logic [XLEN-1:0]   alu_reg,
    input  logic [JUMP_W-1:0] ir_target,
    input  logic              alu_zero,
    input  logic              pc_wr,
    input  logic              pc_wr_cond,
    input  logic              br_ne,
    input  logic [2:0]        pc_sel,
    input  logic              epc_wr,
    input  logic              cause_wr,
    input  logic [CODE_W-1:0] cause_code,
    output logic [XLEN-1:0]   pc_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   cause_q
);

    localparam int HI_W = XLEN - JUMP_W - 2;

    logic            load_en;
    logic            sel_valid;
    logic [XLEN-1:0] next_pc;

    npc_branch_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .pc_wr      (pc_wr),
        .pc_wr_cond (pc_wr_cond),
        .br_ne      (br_ne),
        .alu_zero   (alu_zero),
        .load_en    (load_en)
    );

    npc_source_mux #(
        .XLEN     (XLEN),
        .JUMP_W   (JUMP_W),
        .TRAP_VEC (TRAP_VEC)
    ) u_mux (
        .pc_sel     (pc_sel),
        .alu_result (alu_result),
        .alu_reg    (alu_reg),
        .pc_hi      (pc_q[XLEN-1 -: HI_W]),
        .ir_target  (ir_target),
        .epc_val    (epc_q),
        .next_pc    (next_pc),
        .sel_valid  (sel_valid)
    );

    npc_exc_capture #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) u_exc (
        .clk        (clk),
        .rst        (rst),
        .epc_wr     (epc_wr),
        .alu_result (alu_result),
        .cause_wr   (cause_wr),
        .cause_code (cause_code),
        .epc_q      (epc_q),
        .cause_q    (cause_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (load_en && sel_valid)
            pc_q <= next_pc;
    end

    // R2: no enable, no change
    a_r2_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr || (pc_wr_cond && (alu_zero != br_ne))) |=> $stable(pc_q));

    // R5: trap vector
    a_r5_trap_vector: assert property (@(posedge clk) disable iff (rst)
        (load_en && pc_sel == 3'd3) |=> pc_q == TRAP_VEC[XLEN-1:0]);

    // R6 and R10: return path takes the pre-edge EPC
    a_r6_return_old_epc: assert property (@(posedge clk) disable iff (rst)
        (load_en && pc_sel == 3'd4) |=> pc_q == $past(epc_q));

    // R7: unused selects never move the PC
    a_r7_unused_sel: assert property (@(posedge clk) disable iff (rst)
        (pc_sel >= 3'd5) |=> $stable(pc_q));

    // R1: reset clears all three registers
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && epc_q == '0 && cause_q == '0));

endmodule

// File: tb/tb_npc_pc_unit.sv
module tb_npc_pc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] alu_result, alu_reg;
    logic [25:0] ir_target;
    logic        alu_zero, pc_wr, pc_wr_cond, br_ne;
    logic [2:0]  pc_sel;
    logic        epc_wr, cause_wr;
    logic [0:0]  cause_code;
    logic [31:0] pc_q, epc_q, cause_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_pc, m_epc, m_cause;

    always #2.5 clk = ~clk;

    npc_pc_unit dut (
        .clk(clk), .rst(rst), .alu_result(alu_result), .alu_reg(alu_reg),
        .ir_target(ir_target), .alu_zero(alu_zero), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .br_ne(br_ne), .pc_sel(pc_sel),
        .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_code(cause_code),
        .pc_q(pc_q), .epc_q(epc_q), .cause_q(cause_q)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // drive after a falling edge, one rising edge, then compare against the model
    task automatic cycle_and_check();
        logic        en;
        string       ptag;
        logic [31:0] n_pc;
        en   = pc_wr | (pc_wr_cond & (alu_zero ^ br_ne));
        n_pc = m_pc;
        ptag = "R2";
        if (en) begin
            case (pc_sel)
                3'd0: begin n_pc = alu_result; ptag = "R3"; end
                3'd1: begin n_pc = alu_reg;    ptag = "R3"; end
                3'd2: begin n_pc = {m_pc[31:28], ir_target, 2'b00}; ptag = "R4"; end
                3'd3: begin n_pc = 32'hC000_0000; ptag = "R5"; end
                3'd4: begin n_pc = m_epc; ptag = (epc_wr ? "R10" : "R6"); end
                default: ptag = "R7";
            endcase
        end
        if (epc_wr)   m_epc   = alu_result;
        if (cause_wr) m_cause = {31'b0, cause_code};
        m_pc = n_pc;
        @(posedge clk);
        #1;
        check(ptag, "pc", pc_q, m_pc);
        check("R8", "epc", epc_q, m_epc);
        check("R9", "cause", cause_q, m_cause);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        alu_result = 32'h0; alu_reg = 32'h0; ir_target = 26'h0;
        alu_zero = 0; pc_wr = 0; pc_wr_cond = 0; br_ne = 0;
        pc_sel = 3'd0; epc_wr = 0; cause_wr = 0; cause_code = 1'b0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        #1;
        m_pc = 0; m_epc = 0; m_cause = 0;
        check("R1", "pc", pc_q, 32'h0);
        check("R1", "epc", epc_q, 32'h0);
        check("R1", "cause", cause_q, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        do_reset();

        // exhaustive sweep: sel x wr x cond x zero x bne, with varying data and capture strobes
        for (int rep = 0; rep < 2; rep++) begin
            for (int i = 0; i < 128; i++) begin
                pc_sel     = i[6:4];
                pc_wr      = i[3];
                pc_wr_cond = i[2];
                alu_zero   = i[1];
                br_ne      = i[0];
                alu_result = 32'h9000_0004 ^ (i * 32'h0135_7913) ^ (rep * 32'h5000_0000);
                alu_reg    = 32'h2468_ACE0 ^ (i * 32'h0011_0203);
                ir_target  = 26'(32'h2AB_CDEF ^ (i * 32'h1_0101));
                epc_wr     = (i % 3 == 0);
                cause_wr   = (i % 5 == 1);
                cause_code = 1'(i / 5);
                cycle_and_check();
            end
        end

        // R4: jump keeps a non-zero upper nibble of the PC
        idle_inputs();
        pc_wr = 1; pc_sel = 3'd0; alu_result = 32'hB123_4560;
        cycle_and_check();
        pc_sel = 3'd2; ir_target = 26'h3FF_FFFF;
        cycle_and_check();

        // R10: return and capture in the same cycle
        idle_inputs();
        epc_wr = 1; alu_result = 32'h0040_1234;
        cycle_and_check();
        pc_wr = 1; pc_sel = 3'd4; epc_wr = 1; alu_result = 32'h0077_7770;
        cycle_and_check();
        check("R10", "pc_direct", pc_q, 32'h0040_1234);
        check("R10", "epc_direct", epc_q, 32'h0077_7770);

        // R9: overflow then undefined opcode codes
        idle_inputs();
        cause_wr = 1; cause_code = 1'b1;
        cycle_and_check();
        check("R9", "cause_overflow", cause_q, 32'h1);
        cause_code = 1'b0;
        cycle_and_check();
        check("R9", "cause_undef", cause_q, 32'h0);

        // R7: unused selects with both strobes high
        idle_inputs();
        pc_wr = 1; pc_wr_cond = 1; alu_result = 32'hDEAD_BEE0;
        for (int s = 5; s < 8; s++) begin
            pc_sel = 3'(s);
            cycle_and_check();
        end

        // R1: reset in mid-run after non-zero state
        idle_inputs();
        pc_wr = 1; epc_wr = 1; cause_wr = 1; cause_code = 1'b1;
        alu_result = 32'h1234_5678;
        cycle_and_check();
        do_reset();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule